// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a run of words between one peripheral and memory so that the processor does not touch each word. Software writes a peripheral identifier, a memory base address and a word count into small configuration registers. It then writes the control register with a direction bit and the go bit. The engine asks for the shared bus and waits until the bus is granted. For each word it makes two bus accesses: a read into a one-word holding register, then a write out of that register. After each word the memory pointer moves up by one word and the remaining count drops by one.

When the last word has been written, the engine gives up the bus, goes back to idle and raises one interrupt for the whole block. The interrupt stays high until software clears it through the status register. While a block is running, the status register shows busy and writes to the configuration registers are dropped. A start with a zero count finishes at once and makes no bus access.

The state machine has five states. ST_IDLE waits for a start. It moves to ST_REQ when the count is non-zero and to ST_DONE when the count is zero. ST_REQ holds the bus request and moves to ST_READ once the grant arrives. ST_READ moves to ST_WRITE when the read access completes. ST_WRITE moves back to ST_READ when words remain, or to ST_DONE after the last word. ST_DONE lasts one cycle, sets the interrupt and returns to ST_IDLE.

Top module: `dma_block_ctrl`

## Requirements
- R1: After reset the engine is idle: `bus_req`, `bus_valid` and `irq` are low, and the status register (offset 4) reads 0.
- R2: The register offsets are: 0 control (bit 0 direction, bit 1 go; the go bit is not stored), 1 peripheral identifier, 2 memory base address, 3 word count, 4 status (bit 0 busy, bit 1 interrupt pending). While the engine is idle, every configuration register reads back what was written to it.
- R3: A control write with bit 1 set while idle and with a non-zero count raises `bus_req` in the next cycle. No access (`bus_valid`) happens unless `bus_ack` is high.
- R4: Each word takes a read access and then a write access, and the written data equals the data read. With direction 0 the read goes to the peripheral (`bus_io`=1, address = identifier) and the write goes to memory. With direction 1 the read comes from memory and the write goes to the peripheral.
- R5: Memory accesses start at the base address, and the address rises by one after each word. A block with count N makes exactly 2N accesses.
- R6: After the last word completes, `bus_req` drops, the engine returns to idle and `irq` rises exactly once for the block.
- R7: Status bit 0 reads 1 from start until completion. Writes to offsets 0 to 3 while busy, including a second start, are ignored.
- R8: `irq` stays high until a write to offset 4 with bit 1 set. A status write with bit 1 clear leaves it high.
- R9: A start with a count of 0 raises `irq` without asserting `bus_req` and without any access.
- R10: An access whose `bus_ready` is low is held: `bus_valid`, `bus_write` and `bus_addr` stay unchanged until `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_addr` (combinational) |
| bus_req | output | 1 | Bus ownership request |
| bus_ack | input | 1 | Bus grant |
| bus_valid | output | 1 | Access in progress |
| bus_write | output | 1 | 1 = write access, 0 = read access |
| bus_io | output | 1 | 1 = peripheral space, 0 = memory |
| bus_addr | output | ADDR_W | Memory word address or peripheral identifier |
| bus_wdata | output | DATA_W | Write data from the holding register |
| bus_rdata | input | DATA_W | Read data, taken when `bus_ready` is high |
| bus_ready | input | 1 | Access completes this cycle |
| irq | output | 1 | Block-complete interrupt |

## Verification
Blocks are run in both directions with different identifiers, bases and lengths. Peripheral read data carries a running sequence number and memory content is a function of the address, so the checks can tell a wrong order, a skipped or repeated word, or a swapped direction. One block runs with a randomly withheld `bus_ready` and a late grant, which separates correct wait handling from an engine that runs ahead of the bus. Configuration writes and a second start are issued during a slow block and checked against the block's length and the read-back values afterwards. A zero-count start and status writes with and without the clear bit exercise the interrupt paths.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } xfer_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DEV    = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BASE   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd4;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IRQ_BIT  = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_blk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic              dir_o,
    output logic [DEV_W-1:0]  dev_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o
);

    logic              dir_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic              irq_q;
    logic              wr_ok;
    logic              irq_clr;

    assign wr_ok   = we_i && !busy_i;
    assign irq_clr = we_i && (sel_i == SEL_STATUS) && wdata_i[STAT_IRQ_BIT];
    assign start_o = wr_ok && (sel_i == SEL_CTRL) && wdata_i[CTRL_GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            dev_q   <= '0;
            base_q  <= '0;
            count_q <= '0;
        end else if (wr_ok) begin
            unique case (sel_i)
                SEL_CTRL:  dir_q   <= wdata_i[CTRL_DIR_BIT];
                SEL_DEV:   dev_q   <= wdata_i[DEV_W-1:0];
                SEL_BASE:  base_q  <= wdata_i[ADDR_W-1:0];
                SEL_COUNT: count_q <= wdata_i[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (done_i) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_CTRL:   rdata_o[CTRL_DIR_BIT] = dir_q;
            SEL_DEV:    rdata_o = DATA_W'(dev_q);
            SEL_BASE:   rdata_o = DATA_W'(base_q);
            SEL_COUNT:  rdata_o = DATA_W'(count_q);
            SEL_STATUS: begin
                rdata_o[STAT_BUSY_BIT] = busy_i;
                rdata_o[STAT_IRQ_BIT]  = irq_q;
            end
            default:    rdata_o = '0;
        endcase
    end

    assign dir_o   = dir_q;
    assign dev_o   = dev_q;
    assign base_o  = base_q;
    assign count_o = count_q;
    assign irq_o   = irq_q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> ($stable(dir_q) && $stable(dev_q) && $stable(base_q) && $stable(count_q))); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q); // R8

    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(done_i)); // R6

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_blk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_req_o,
    input  logic              bus_ack_i,
    output logic              bus_valid_o,
    output logic              bus_write_o,
    output logic              bus_io_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ready_i
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    xfer_state_e       state_q;
    xfer_state_e       state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] buf_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (count_i == '0) ? ST_DONE : ST_REQ;
            ST_REQ:   if (bus_ack_i) state_d = ST_READ;
            ST_READ:  if (bus_ready_i) state_d = ST_WRITE;
            ST_WRITE: if (bus_ready_i) state_d = (left_q == CNT_ONE) ? ST_DONE : ST_READ;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // pointer, remaining count and one-word holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
            buf_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                ptr_q  <= base_i;
                left_q <= count_i;
            end
            if (state_q == ST_READ && bus_ready_i) begin
                buf_q <= bus_rdata_i;
            end
            if (state_q == ST_WRITE && bus_ready_i) begin
                ptr_q  <= ptr_q + ADDR_ONE;
                left_q <= left_q - CNT_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_valid_o = 1'b0;
        bus_write_o = 1'b0;
        bus_io_o    = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   bus_req_o = 1'b1;
            ST_READ: begin
                bus_req_o   = 1'b1;
                bus_valid_o = 1'b1;
                bus_io_o    = !dir_i;
            end
            ST_WRITE: begin
                bus_req_o   = 1'b1;
                bus_valid_o = 1'b1;
                bus_write_o = 1'b1;
                bus_io_o    = dir_i;
            end
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign bus_addr_o  = bus_io_o ? ADDR_W'(dev_i) : ptr_q;
    assign bus_wdata_o = buf_q;

    AST_ACCESS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (bus_req_o && bus_ack_i)); // R3

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o) && $stable(bus_write_o))); // R10

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && bus_ready_i) |=> (left_q == $past(left_q) - CNT_ONE && ptr_q == $past(ptr_q) + ADDR_ONE)); // R5

    AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && count_i == '0) |=> (!bus_req_o && done_o)); // R9

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_write_o && bus_ready_i) |=> (bus_valid_o && bus_write_o)); // R4

endmodule

// File: rtl/dma_block_ctrl.sv
module dma_block_ctrl
    import dma_blk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              irq
);

    logic              start;
    logic              dir;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  count;
    logic              busy;
    logic              done;

    dma_cfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEV_W  (DEV_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .start_o (start),
        .dir_o   (dir),
        .dev_o   (dev),
        .base_o  (base),
        .count_o (count),
        .irq_o   (irq)
    );

    dma_xfer_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEV_W  (DEV_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .dir_i       (dir),
        .dev_i       (dev),
        .base_i      (base),
        .count_i     (count),
        .busy_o      (busy),
        .done_o      (done),
        .bus_req_o   (bus_req),
        .bus_ack_i   (bus_ack),
        .bus_valid_o (bus_valid),
        .bus_write_o (bus_write),
        .bus_io_o    (bus_io),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_rdata_i (bus_rdata),
        .bus_ready_i (bus_ready)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !bus_valid)); // R6

endmodule

// File: tb/dma_block_ctrl_test.sv
module dma_block_ctrl_test;

    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          bus_req;
    logic          bus_ack = 1'b0;
    logic          bus_valid;
    logic          bus_write;
    logic          bus_io;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready = 1'b1;
    logic          irq;

    always #4 clk = ~clk;  // 125 MHz

    dma_block_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq)
    );

    int tests = 0;
    int fails = 0;

    // bus models
    logic [DW-1:0] mem     [0:255];
    logic          mem_vld [0:255];
    logic [DW-1:0] dev_log [0:63];
    int            dev_rd_cnt = 0;
    int            dev_wr_cnt = 0;
    int            acc_cnt = 0;
    int            req_cycles = 0;
    int            irq_rises = 0;
    int            hold_err = 0;
    int            own_err = 0;
    logic [AW-1:0] last_io_addr = '0;
    logic          prev_wait = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          prev_irq = 1'b0;
    int            grant_lat = 0;
    int            wait_cnt = 0;
    logic          stall_en = 1'b0;
    logic [7:0]    lfsr = 8'hB7;
    int            cyc = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem_vld[i] = 1'b0;
    end

    function automatic logic [DW-1:0] seed(input logic [AW-1:0] a);
        return a ^ 16'hA5C3;
    endfunction

    assign bus_rdata = bus_io ? {4'hD, bus_addr[3:0], dev_rd_cnt[7:0]}
                              : (mem_vld[bus_addr[7:0]] ? mem[bus_addr[7:0]] : seed(bus_addr));

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_req) req_cycles <= req_cycles + 1;
            if (irq && !prev_irq) irq_rises <= irq_rises + 1;
            if (prev_wait && !(bus_valid && bus_addr == prev_addr)) hold_err <= hold_err + 1;
            if (bus_valid && !bus_ack) own_err <= own_err + 1;
            if (bus_valid && bus_ready) begin
                acc_cnt <= acc_cnt + 1;
                if (bus_write) begin
                    if (bus_io) begin
                        dev_log[dev_wr_cnt[5:0]] <= bus_wdata;
                        dev_wr_cnt <= dev_wr_cnt + 1;
                        last_io_addr <= bus_addr;
                    end else begin
                        mem[bus_addr[7:0]] <= bus_wdata;
                        mem_vld[bus_addr[7:0]] <= 1'b1;
                    end
                end else if (bus_io) begin
                    dev_rd_cnt <= dev_rd_cnt + 1;
                end
            end
        end
        prev_irq  <= irq;
        prev_wait <= bus_valid && !bus_ready;
        prev_addr <= bus_addr;
    end

    always @(negedge clk) begin
        if (!bus_req) begin
            bus_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (wait_cnt >= grant_lat) begin
            bus_ack <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + 1;
        end
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [DW-1:0] v;
        check("R1 bus_req after reset", int'(bus_req), 0);
        check("R1 irq after reset", int'(irq), 0);
        cfg_rd(3'd4, v);
        check("R1 status after reset", int'(v), 0);
        check("R1 bus_valid after reset", int'(bus_valid), 0);
    endtask

    task automatic test_regs();
        logic [DW-1:0] v;
        cfg_wr(3'd1, 16'h0005);
        cfg_wr(3'd2, 16'h0020);
        cfg_wr(3'd3, 16'h0003);
        cfg_wr(3'd0, 16'h0001);
        cfg_rd(3'd1, v); check("R2 identifier readback", int'(v), 5);
        cfg_rd(3'd2, v); check("R2 base readback", int'(v), 16'h20);
        cfg_rd(3'd3, v); check("R2 count readback", int'(v), 3);
        cfg_rd(3'd0, v); check("R2 direction readback", int'(v), 1);
        check("R2 no transfer without go bit", req_cycles, 0);
    endtask

    task automatic test_dev_to_mem();
        logic [DW-1:0] v;
        int rd0, acc0, rise0;
        grant_lat = 3;
        rd0 = dev_rd_cnt; acc0 = acc_cnt; rise0 = irq_rises;
        cfg_wr(3'd1, 16'h0007);
        cfg_wr(3'd2, 16'h0040);
        cfg_wr(3'd3, 16'h0004);
        cfg_wr(3'd0, 16'h0002);
        #1;
        check("R3 bus_req after start", int'(bus_req), 1);
        check("R3 no access before grant", int'(bus_valid), 0);
        wait_irq();
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            check("R4 R5 memory word from peripheral", int'(mem[8'h40 + i]),
                  int'({4'hD, 4'h7, 8'(rd0 + i)}));
        check("R5 access count 2N", acc_cnt - acc0, 8);
        check("R3 accesses only with grant", own_err, 0);
        check("R6 bus_req dropped", int'(bus_req), 0);
        check("R6 single irq rise", irq_rises - rise0, 1);
        cfg_rd(3'd4, v);
        check("R6 status idle and pending", int'(v), 2);
        check("R5 word after block untouched", int'(mem_vld[8'h44]), 0);
        cfg_wr(3'd4, 16'h0002);
        #1;
        check("R8 irq cleared by status write", int'(irq), 0);
    endtask

    task automatic test_mem_to_dev();
        int wr0, acc0;
        grant_lat = 5;
        stall_en = 1'b1;
        wr0 = dev_wr_cnt; acc0 = acc_cnt;
        cfg_wr(3'd1, 16'h0009);
        cfg_wr(3'd2, 16'h0080);
        cfg_wr(3'd3, 16'h0005);
        cfg_wr(3'd0, 16'h0003);
        wait_irq();
        @(negedge clk);
        stall_en = 1'b0;
        for (int i = 0; i < 5; i++)
            check("R4 R5 peripheral word from memory", int'(dev_log[6'(wr0 + i)]),
                  int'(seed(AW'(16'h80 + i))));
        check("R4 peripheral address is identifier", int'(last_io_addr), 9);
        check("R5 access count 2N with waits", acc_cnt - acc0, 10);
        check("R10 access held while not ready", hold_err, 0);
        check("R6 irq raised", int'(irq), 1);
        cfg_wr(3'd4, 16'h0002);
    endtask

    task automatic test_busy();
        logic [DW-1:0] v;
        int acc0, req0;
        grant_lat = 12;
        acc0 = acc_cnt;
        cfg_wr(3'd1, 16'h0003);
        cfg_wr(3'd2, 16'h0010);
        cfg_wr(3'd3, 16'h0006);
        cfg_wr(3'd0, 16'h0002);
        cfg_rd(3'd4, v);
        check("R7 busy bit during block", int'(v[0]), 1);
        cfg_wr(3'd2, 16'h0099);
        cfg_wr(3'd3, 16'h0001);
        cfg_wr(3'd1, 16'h000C);
        cfg_wr(3'd0, 16'h0003);
        wait_irq();
        @(negedge clk);
        req0 = req_cycles;
        repeat (20) @(negedge clk);
        check("R7 second start ignored", req_cycles - req0, 0);
        check("R7 block length kept", acc_cnt - acc0, 12);
        cfg_rd(3'd2, v); check("R7 base write ignored", int'(v), 16'h10);
        cfg_rd(3'd3, v); check("R7 count write ignored", int'(v), 6);
        cfg_rd(3'd1, v); check("R7 identifier write ignored", int'(v), 3);
        cfg_rd(3'd0, v); check("R7 direction write ignored", int'(v), 0);
        cfg_rd(3'd4, v); check("R7 busy clear after block", int'(v[0]), 0);
    endtask

    task automatic test_irq_hold();
        cfg_wr(3'd4, 16'h0001);
        repeat (3) @(negedge clk);
        check("R8 irq held after write without clear bit", int'(irq), 1);
        cfg_wr(3'd4, 16'h0002);
        #1;
        check("R8 irq cleared", int'(irq), 0);
    endtask

    task automatic test_zero();
        int acc0, req0, rise0;
        acc0 = acc_cnt; req0 = req_cycles; rise0 = irq_rises;
        cfg_wr(3'd3, 16'h0000);
        cfg_wr(3'd0, 16'h0002);
        repeat (4) @(negedge clk);
        check("R9 irq on zero count", int'(irq), 1);
        check("R9 no bus request", req_cycles - req0, 0);
        check("R9 no access", acc_cnt - acc0, 0);
        check("R9 one irq rise", irq_rises - rise0, 1);
        cfg_wr(3'd4, 16'h0002);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_dev_to_mem();
        test_mem_to_dev();
        test_busy();
        test_irq_hold();
        test_zero();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule